// File: doc/BRIEF.md
# Dual-Channel Host Mailbox

This block passes single bytes between an external host bus and an on-chip slave processor. It has two channels, and each channel has its own active-low host select. In each channel the host can drop one byte for the slave, and the slave can leave one byte for the host. A flag marks each direction as full. A third flag records whether the last host byte was a command or data. The host bus is asynchronous. All of its strobes, selects, the address bit and the data byte pass through two-flop synchronizers, and edges are then detected in the slave clock domain. Every flag and register update happens in that domain.

The slave uses a plain synchronous register port. It gives a channel index, a register select (0 = mailbox byte, 1 = status) and one-cycle read or write strobes. Each channel raises its slave interrupt while its inbound byte is unread. The host side uses no valid/ready pair, because the strobes carry the handshake. A host byte is taken only at the end of a write strobe. A slave byte is released only by the end of a host read. This means neither side can overrun the other without first seeing the full flag.

Top module: `mbox_bridge`

## Requirements
- R1: At the synchronized rising edge of `host_wr_n` while `host_sel_n[c]` is low, `host_wdata` is stored as channel c's inbound byte. A slave read with `sl_reg`=0 returns that byte on `sl_rdata` the cycle after the strobe.
- R2: Each host write to channel c copies `host_addr` into that channel's command flag: 1 means command, 0 means data.
- R3: A host write sets channel c's inbound-full flag. That flag is cleared on the cycle after a slave read strobe with `sl_reg`=0 to channel c ends, which is its falling edge.
- R4: A slave write with `sl_reg`=0 captures `sl_wdata` as channel c's outbound byte and sets outbound-full when the strobe falls. A host read with `host_addr`=0 returns that byte and clears outbound-full at the rising edge of `host_rd_n`.
- R5: A host read with `host_addr`=1 returns the channel status and leaves outbound-full unchanged.
- R6: Status byte layout: bit 0 is outbound-full, bit 1 is inbound-full, bit 3 is the command flag. All other bits read 0.
- R7: `irq[c]` is high exactly while channel c's inbound-full flag is set.
- R8: Host strobes while a channel's select is high leave that channel's byte, flags and interrupt unchanged.
- R9: After reset, all flags and all interrupts are 0.
- R10: Activity on one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 2 | Active-low host select, one per channel |
| host_addr | input | 1 | Host address bit: command/status when high |
| host_wr_n | input | 1 | Active-low host write strobe (asynchronous) |
| host_rd_n | input | 1 | Active-low host read strobe (asynchronous) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, updated at start of a read |
| sl_ch | input | 1 | Slave channel index |
| sl_reg | input | 1 | Slave register select: 0 byte, 1 status |
| sl_wr | input | 1 | Slave write strobe |
| sl_rd | input | 1 | Slave read strobe |
| sl_wdata | input | 8 | Slave write data |
| sl_rdata | output | 8 | Slave read data, valid the cycle after `sl_rd` |
| irq | output | 2 | Per-channel slave interrupt |

## Verification
The assertions take four things for granted about the inputs. The host holds select, address and data steady from before a strobe edge until the edge has crossed the synchronizers. Slave strobes carry a valid channel index. The slave never reads and writes in the same cycle. The stimulus follows these rules by holding every host signal for several clocks on each side of each strobe edge, and by changing slave inputs only at falling clock edges with single-cycle strobes. Under these conditions, a new interrupt can only follow a synchronized host write, and status reads never show reserved bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W   = 8;
  localparam int ST_OUT_B = 0;
  localparam int ST_IN_B  = 1;
  localparam int ST_CMD_B = 3;

  typedef struct packed {
    logic cmd;
    logic in_full;
    logic out_full;
  } chan_flags_t;

  function automatic logic [BYTE_W-1:0] pack_status(chan_flags_t f);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_OUT_B] = f.out_full;
    s[ST_IN_B]  = f.in_full;
    s[ST_CMD_B] = f.cmd;
    return s;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_host_front.sv
module mbox_host_front #(
  parameter int NCH    = 2,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sel_n,
  input  logic           addr,
  input  logic           wr_n,
  input  logic           rd_n,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] wr_evt,
  output logic [NCH-1:0] rd_start,
  output logic [NCH-1:0] rd_end,
  output logic           addr_s,
  output logic [DW-1:0]  wdata_s
);
  localparam int CW = NCH + 3;

  logic [CW-1:0] ctl_s;
  logic [NCH-1:0] sel_s;
  logic wr_s, rd_s, wr_q, rd_q;

  mbox_sync #(.W(CW), .STAGES(STAGES), .RST_VAL({CW{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, addr, wr_n, rd_n}), .q(ctl_s)
  );
  mbox_sync #(.W(DW), .STAGES(STAGES), .RST_VAL({DW{1'b0}})) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(wdata), .q(wdata_s)
  );

  assign sel_s  = ctl_s[CW-1:3];
  assign addr_s = ctl_s[2];
  assign wr_s   = ctl_s[1];
  assign rd_s   = ctl_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_evt
      assign wr_evt[c]   = wr_s & ~wr_q & ~sel_s[c];
      assign rd_start[c] = ~rd_s & rd_q & ~sel_s[c];
      assign rd_end[c]   = rd_s & ~rd_q & ~sel_s[c];
    end
  endgenerate
endmodule

// File: rtl/mbox_slave_port.sv
module mbox_slave_port #(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  sl_ch,
  input  logic           sl_reg,
  input  logic           sl_wr,
  input  logic           sl_rd,
  output logic [NCH-1:0] wr_hit,
  output logic [NCH-1:0] wr_done,
  output logic [NCH-1:0] rd_done
);
  logic          rd_q, wr_q, reg_q;
  logic [CW-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      reg_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      rd_q  <= sl_rd;
      wr_q  <= sl_wr;
      reg_q <= sl_reg;
      ch_q  <= sl_ch;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_dec
      assign wr_hit[c]  = sl_wr & ~sl_reg & (sl_ch == CW'(c));
      assign wr_done[c] = wr_q & ~sl_wr & ~reg_q & (ch_q == CW'(c));
      assign rd_done[c] = rd_q & ~sl_rd & ~reg_q & (ch_q == CW'(c));
    end
  endgenerate
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_addr,
  input  logic [DW-1:0] host_byte,
  input  logic          host_rd_end,
  input  logic          sl_wr_hit,
  input  logic          sl_wr_done,
  input  logic          sl_rd_done,
  input  logic [DW-1:0] sl_byte,
  output logic [DW-1:0] in_byte,
  output logic [DW-1:0] out_byte,
  output chan_flags_t   flags
);
  always_ff @(posedge clk) begin
    if (host_wr)   in_byte  <= host_byte;
    if (sl_wr_hit) out_byte <= sl_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (host_wr) flags.cmd <= host_addr;
      if (host_wr) flags.in_full <= 1'b1;
      else if (sl_rd_done) flags.in_full <= 1'b0;
      if (sl_wr_done) flags.out_full <= 1'b1;
      else if (host_rd_end && !host_addr) flags.out_full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int STAGES = 2,
  localparam int DW    = BYTE_W,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] host_sel_n,
  input  logic           host_addr,
  input  logic           host_wr_n,
  input  logic           host_rd_n,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic [CW-1:0]  sl_ch,
  input  logic           sl_reg,
  input  logic           sl_wr,
  input  logic           sl_rd,
  input  logic [DW-1:0]  sl_wdata,
  output logic [DW-1:0]  sl_rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] host_wr_evt, host_rd_start, host_rd_end;
  logic           host_addr_s;
  logic [DW-1:0]  host_wdata_s;
  logic [NCH-1:0] sl_wr_hit, sl_wr_done, sl_rd_done;
  logic [DW-1:0]  in_byte  [NCH];
  logic [DW-1:0]  out_byte [NCH];
  logic [DW-1:0]  status   [NCH];
  chan_flags_t    flags    [NCH];

  mbox_host_front #(.NCH(NCH), .DW(DW), .STAGES(STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sel_n(host_sel_n), .addr(host_addr),
    .wr_n(host_wr_n), .rd_n(host_rd_n), .wdata(host_wdata),
    .wr_evt(host_wr_evt), .rd_start(host_rd_start), .rd_end(host_rd_end),
    .addr_s(host_addr_s), .wdata_s(host_wdata_s)
  );

  mbox_slave_port #(.NCH(NCH), .CW(CW)) u_slave (
    .clk(clk), .rst_n(rst_n), .sl_ch(sl_ch), .sl_reg(sl_reg),
    .sl_wr(sl_wr), .sl_rd(sl_rd),
    .wr_hit(sl_wr_hit), .wr_done(sl_wr_done), .rd_done(sl_rd_done)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      mbox_chan #(.DW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr_evt[c]), .host_addr(host_addr_s),
        .host_byte(host_wdata_s), .host_rd_end(host_rd_end[c]),
        .sl_wr_hit(sl_wr_hit[c]), .sl_wr_done(sl_wr_done[c]),
        .sl_rd_done(sl_rd_done[c]), .sl_byte(sl_wdata),
        .in_byte(in_byte[c]), .out_byte(out_byte[c]), .flags(flags[c])
      );
      assign status[c] = pack_status(flags[c]);
      assign irq[c]    = flags[c].in_full;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (host_rd_start[c])
          host_rdata <= host_addr_s ? status[c] : out_byte[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sl_rdata <= '0;
    else if (sl_rd) sl_rdata <= sl_reg ? status[sl_ch] : in_byte[sl_ch];
  end
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  sl_ch,
  input logic           sl_reg,
  input logic           sl_rd,
  input logic [7:0]     sl_rdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] wr_evt
);
  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sl_rd) && $past(sl_reg)) |-> (sl_rdata[7:4] == 4'h0 && !sl_rdata[2])); // R6

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ast
      AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt[c] |=> irq[c]); // R3
      AST_IRQ_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[c]) |-> $past(wr_evt[c])); // R8
      AST_IRQ_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sl_rd) && !sl_rd && !$past(sl_reg) && $past(sl_ch) == CW'(c) && !wr_evt[c])
        |=> !irq[c]); // R3
      AST_STATUS_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sl_rd) && $past(sl_reg) && $past(sl_ch) == CW'(c))
        |-> (sl_rdata[1] == $past(irq[c]))); // R7
    end
  endgenerate
endmodule

bind mbox_bridge mbox_bridge_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sl_ch(sl_ch), .sl_reg(sl_reg), .sl_rd(sl_rd),
  .sl_rdata(sl_rdata), .irq(irq), .wr_evt(host_wr_evt)
);

// File: tb/mbox_bridge_bench.sv
`timescale 1ns/1ps
module mbox_bridge_bench;
  logic       clk = 0, rst_n = 0;
  logic [1:0] host_sel_n = 2'b11;
  logic       host_addr = 0, host_wr_n = 1, host_rd_n = 1;
  logic [7:0] host_wdata = 0, host_rdata, sl_wdata = 0, sl_rdata;
  logic [0:0] sl_ch = 0;
  logic       sl_reg = 0, sl_wr = 0, sl_rd = 0;
  logic [1:0] irq;

  typedef struct { string req; logic [7:0] val; } item_t;
  item_t exp_q[$], act_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_bridge u_mbox_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_addr(host_addr),
    .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .sl_ch(sl_ch), .sl_reg(sl_reg), .sl_wr(sl_wr),
    .sl_rd(sl_rd), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata), .irq(irq)
  );

  // scoreboard monitor
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        checks++;
        if (a.val !== e.val) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", e.req, a.val, e.val);
        end
      end
    end
  end

  task automatic push(string req, logic [7:0] e, logic [7:0] a);
    exp_q.push_back('{req, e});
    act_q.push_back('{req, a});
    #1;
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [1:0] sel, logic a, logic [7:0] d);
    @(negedge clk);
    host_sel_n = sel; host_addr = a; host_wdata = d;
    clks(2); host_wr_n = 0;
    clks(4); host_wr_n = 1;
    clks(6); host_sel_n = 2'b11;
    clks(2);
  endtask

  task automatic host_read(logic [1:0] sel, logic a, output logic [7:0] d);
    @(negedge clk);
    host_sel_n = sel; host_addr = a;
    clks(2); host_rd_n = 0;
    clks(6); d = host_rdata;
    host_rd_n = 1;
    clks(6); host_sel_n = 2'b11;
    clks(2);
  endtask

  task automatic slave_read(logic ch, logic r, output logic [7:0] d);
    @(negedge clk);
    sl_ch = ch; sl_reg = r; sl_rd = 1;
    @(negedge clk);
    sl_rd = 0; d = sl_rdata;
    clks(2);
  endtask

  task automatic slave_write(logic ch, logic [7:0] d);
    @(negedge clk);
    sl_ch = ch; sl_reg = 0; sl_wdata = d; sl_wr = 1;
    @(negedge clk);
    sl_wr = 0;
    clks(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    clks(3); rst_n = 1; clks(2);
    push("R9 irq after reset", 8'h00, {6'b0, irq});
    slave_read(0, 1, v); push("R9 ch0 status after reset", 8'h00, v);
    slave_read(1, 1, v); push("R9 ch1 status after reset", 8'h00, v);

    // host write data byte, slave reads it
    host_write(2'b10, 0, 8'h5A);
    push("R7 irq after write", 8'h01, {6'b0, irq});
    slave_read(0, 1, v); push("R2 R6 status data write", 8'h02, v);
    slave_read(0, 0, v); push("R1 inbound byte", 8'h5A, v);
    push("R3 irq after slave read", 8'h00, {6'b0, irq});
    slave_read(0, 1, v); push("R3 status after slave read", 8'h00, v);

    // command write
    host_write(2'b10, 1, 8'hC3);
    slave_read(0, 1, v); push("R2 status command write", 8'h0A, v);
    slave_read(0, 0, v); push("R1 command byte", 8'hC3, v);

    // slave write, host reads
    slave_write(1, 8'h77);
    host_read(2'b01, 1, v); push("R6 host status outbound full", 8'h01, v);
    host_read(2'b01, 1, v); push("R5 status read keeps full", 8'h01, v);
    host_read(2'b01, 0, v); push("R4 host outbound byte", 8'h77, v);
    host_read(2'b01, 1, v); push("R4 outbound cleared", 8'h00, v);

    // write with selects high
    host_write(2'b11, 0, 8'h11);
    push("R8 irq unchanged", 8'h00, {6'b0, irq});
    slave_read(0, 1, v); push("R8 status unchanged", 8'h08, v);
    slave_read(0, 0, v); push("R8 byte unchanged", 8'hC3, v);

    // independence and combined flags
    host_write(2'b01, 1, 8'h99);
    slave_read(0, 1, v); push("R10 ch0 untouched", 8'h08, v);
    push("R7 irq ch1 only", 8'h02, {6'b0, irq});
    slave_write(1, 8'h33);
    slave_read(1, 1, v); push("R6 all flags", 8'h0B, v);
    slave_read(1, 0, v); push("R1 ch1 byte", 8'h99, v);

    wait (act_q.size() == 0);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule